// File: doc/BRIEF.md
# Polyphase Filter Bank Channelizer Front-End

This block is the filtering half of a uniform, critically decimated channelizer. A stream of real signed samples arrives one per accepted valid strobe. A rotating commutator hands each sample to one of `D` branches. Each branch is a short FIR filter whose taps are a decimated slice of one shared prototype low-pass filter. After every `D` accepted samples the block produces one frame of `D` branch results, in ascending branch order, for a downstream `D`-point FFT to consume.

The prototype coefficients (`8·D` of them) live in a single coefficient memory that is loaded through a plain write port. Each branch keeps its last eight samples in a circular slot set with its own write pointer. One multiplier and one accumulator serve all branches in turn, eight taps per branch. While a frame is being computed the block holds its input ready low. The result is rounded half-up and shifted down to the output width.

Top module: `pfb_channelizer`

## Requirements
- R1: Accepted sample number j (counted from 0 since reset) goes to branch D-1-(j mod D); a frame of results is started by the accept of every D-th sample, and for frame m the value of branch k uses the samples numbered mD+D-1-k-nD for n = 0..7 (a negative number counts as zero).
- R2: Tap n of branch k is weighted by the coefficient stored at write address n·D+k, so every branch has exactly eight taps taken from one shared table of 8·D entries.
- R3: A frame is D words with out_index 0,1,..,D-1 in that order; out_first is high only together with the word of index 0, and out_valid is high for exactly one cycle in every eight while a frame is out.
- R4: Each word equals (S + 2^(SHIFT-1)) >> SHIFT (arithmetic shift), where S is the full-precision sum of the eight sample-coefficient products; full-scale samples against full-scale coefficients do not overflow.
- R5: in_ready drops in the cycle after the frame-starting accept and stays low for 8·D cycles; the first word appears in the ninth cycle after that accept; a sample offered while in_ready is low is not taken.
- R6: A synchronous reset clears every branch history and the commutator phase, so the next frame is started by the D-th sample after reset and sees no samples from before it.
- R7: A coefficient write takes effect for every frame computed after it.
- R8: After reset out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block will take the offered sample at this edge |
| in_sample | input | DW | Signed input sample |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | log2(8·D) | Prototype tap address |
| coef_data | input | CW | Signed coefficient value |
| out_valid | output | 1 | Branch result valid |
| out_first | output | 1 | Marks the first word (branch 0) of a frame |
| out_index | output | log2(D) | Branch number of the current word |
| out_data | output | OW | Rounded signed branch result |

## Verification
The hardest case to reach from the ports is the interaction of the commutator with the eight-deep branch histories: a given coefficient address only influences one output once its sample has travelled n frames down one branch. The bench drives a single impulse followed by zeros for eight frames, so each frame exposes a different tap row of the prototype table on exactly one branch, and then runs pseudo-random and full-scale streams through a direct sum model. A sample is held on the input during the whole stall, and a reset is forced with a frame half-filled, so that a lost or leaked sample would show up in the next frame's values.

// File: rtl/pfb_pkg.sv
package pfb_pkg;
    typedef enum logic {
        ENG_IDLE = 1'b0,
        ENG_RUN  = 1'b1
    } eng_mode_e;
endpackage

// File: rtl/pfb_coef_ram.sv
module pfb_coef_ram #(
    parameter int D    = 16,
    parameter int NTAP = 8,
    parameter int CW   = 18,
    localparam int CAW = $clog2(D * NTAP)
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [CAW-1:0]       waddr,
    input  logic signed [CW-1:0] wdata,
    input  logic [CAW-1:0]       raddr,
    output logic signed [CW-1:0] rdata
);
    logic signed [CW-1:0] mem_q [D * NTAP];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/pfb_delay_ram.sv
module pfb_delay_ram #(
    parameter int D    = 16,
    parameter int NTAP = 8,
    parameter int DW   = 14,
    localparam int BW  = $clog2(D),
    localparam int TW  = $clog2(NTAP)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [BW-1:0]        wbranch,
    input  logic signed [DW-1:0] wdata,
    input  logic [BW-1:0]        rbranch,
    input  logic [TW-1:0]        rtap,
    output logic signed [DW-1:0] rdata
);
    logic signed [DW-1:0] lane_rd [D];

    for (genvar b = 0; b < D; b++) begin : g_lane
        logic [TW-1:0]        wp_q;
        logic signed [DW-1:0] slot_q [NTAP];
        logic [TW-1:0]        rd_slot;

        always_ff @(posedge clk) begin
            if (rst) begin
                wp_q <= '0;
                for (int s = 0; s < NTAP; s++) begin
                    slot_q[s] <= '0;
                end
            end else if (we && (wbranch == BW'(b))) begin
                slot_q[wp_q] <= wdata;
                wp_q         <= wp_q + 1'b1;
            end
        end

        // newest sample sits one slot behind the write pointer
        assign rd_slot    = TW'(wp_q - TW'(1) - rtap);
        assign lane_rd[b] = slot_q[rd_slot];
    end

    assign rdata = lane_rd[rbranch];
endmodule

// File: rtl/pfb_engine.sv
module pfb_engine
    import pfb_pkg::*;
#(
    parameter int D     = 16,
    parameter int NTAP  = 8,
    parameter int DW    = 14,
    parameter int CW    = 18,
    parameter int OW    = 18,
    parameter int SHIFT = 17,
    localparam int BW   = $clog2(D),
    localparam int TW   = $clog2(NTAP),
    localparam int CAW  = BW + TW,
    localparam int AW   = DW + CW + TW
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    output logic                 in_ready,
    output logic                 wr_en,
    output logic [BW-1:0]        wr_branch,
    output logic [BW-1:0]        rd_branch,
    output logic [TW-1:0]        rd_tap,
    output logic [CAW-1:0]       coef_raddr,
    input  logic signed [CW-1:0] coef_rdata,
    input  logic signed [DW-1:0] samp_rdata,
    output logic                 out_valid,
    output logic                 out_first,
    output logic [BW-1:0]        out_index,
    output logic signed [OW-1:0] out_data
);
    typedef struct packed {
        eng_mode_e      mode;
        logic [BW-1:0]  phase;
        logic [BW-1:0]  bk;
        logic [TW-1:0]  tn;
        logic [AW-1:0]  acc;
        logic           ov;
        logic           of;
        logic [BW-1:0]  oi;
        logic [OW-1:0]  od;
    } eng_st_t;

    eng_st_t st_d, st_q;

    logic                       accept;
    logic signed [DW+CW-1:0]    prod;
    logic signed [AW-1:0]       sum;
    logic signed [AW-1:0]       rsum;

    assign prod = coef_rdata * samp_rdata;
    assign sum  = $signed(st_q.acc) + AW'(prod);
    assign rsum = sum + (AW'(1) <<< (SHIFT - 1));

    always_comb begin
        st_d    = st_q;
        st_d.ov = 1'b0;
        st_d.of = 1'b0;
        accept  = in_valid && (st_q.mode == ENG_IDLE);

        if (accept) begin
            if (st_q.phase == BW'(D - 1)) begin
                st_d.phase = '0;
                st_d.mode  = ENG_RUN;
                st_d.bk    = '0;
                st_d.tn    = '0;
                st_d.acc   = '0;
            end else begin
                st_d.phase = st_q.phase + 1'b1;
            end
        end

        if (st_q.mode == ENG_RUN) begin
            if (st_q.tn == TW'(NTAP - 1)) begin
                st_d.ov  = 1'b1;
                st_d.of  = (st_q.bk == '0);
                st_d.oi  = st_q.bk;
                st_d.od  = OW'(rsum >>> SHIFT);
                st_d.acc = '0;
                st_d.tn  = '0;
                st_d.bk  = st_q.bk + 1'b1;
                if (st_q.bk == BW'(D - 1)) begin
                    st_d.mode = ENG_IDLE;
                end
            end else begin
                st_d.tn  = st_q.tn + 1'b1;
                st_d.acc = sum;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready   = (st_q.mode == ENG_IDLE);
    assign wr_en      = accept;
    assign wr_branch  = BW'(D - 1) - st_q.phase;
    assign rd_branch  = st_q.bk;
    assign rd_tap     = st_q.tn;
    // tap n of branch k lives at n*D + k; D is a power of two
    assign coef_raddr = {st_q.tn, st_q.bk};
    assign out_valid  = st_q.ov;
    assign out_first  = st_q.of;
    assign out_index  = st_q.oi;
    assign out_data   = $signed(st_q.od);
endmodule

// File: rtl/pfb_channelizer.sv
module pfb_channelizer #(
    parameter int D     = 16,
    parameter int NTAP  = 8,
    parameter int DW    = 14,
    parameter int CW    = 18,
    parameter int OW    = 18,
    parameter int SHIFT = 17,
    localparam int BW   = $clog2(D),
    localparam int TW   = $clog2(NTAP),
    localparam int CAW  = BW + TW
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic signed [DW-1:0] in_sample,
    input  logic                 coef_we,
    input  logic [CAW-1:0]       coef_addr,
    input  logic signed [CW-1:0] coef_data,
    output logic                 out_valid,
    output logic                 out_first,
    output logic [BW-1:0]        out_index,
    output logic signed [OW-1:0] out_data
);
    logic                 wr_en;
    logic [BW-1:0]        wr_branch;
    logic [BW-1:0]        rd_branch;
    logic [TW-1:0]        rd_tap;
    logic [CAW-1:0]       coef_raddr;
    logic signed [CW-1:0] coef_rdata;
    logic signed [DW-1:0] samp_rdata;

    pfb_coef_ram #(.D(D), .NTAP(NTAP), .CW(CW)) u_coef (
        .clk   (clk),
        .we    (coef_we),
        .waddr (coef_addr),
        .wdata (coef_data),
        .raddr (coef_raddr),
        .rdata (coef_rdata)
    );

    pfb_delay_ram #(.D(D), .NTAP(NTAP), .DW(DW)) u_hist (
        .clk     (clk),
        .rst     (rst),
        .we      (wr_en),
        .wbranch (wr_branch),
        .wdata   (in_sample),
        .rbranch (rd_branch),
        .rtap    (rd_tap),
        .rdata   (samp_rdata)
    );

    pfb_engine #(
        .D(D), .NTAP(NTAP), .DW(DW), .CW(CW), .OW(OW), .SHIFT(SHIFT)
    ) u_eng (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .wr_en      (wr_en),
        .wr_branch  (wr_branch),
        .rd_branch  (rd_branch),
        .rd_tap     (rd_tap),
        .coef_raddr (coef_raddr),
        .coef_rdata (coef_rdata),
        .samp_rdata (samp_rdata),
        .out_valid  (out_valid),
        .out_first  (out_first),
        .out_index  (out_index),
        .out_data   (out_data)
    );
endmodule

// File: rtl/pfb_chk.sv
module pfb_chk #(
    parameter int D    = 16,
    parameter int NTAP = 8,
    parameter int BW   = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          in_ready,
    input logic          out_valid,
    input logic          out_first,
    input logic [BW-1:0] out_index
);
    logic [BW-1:0] take_cnt_q;
    logic [BW-1:0] last_idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            take_cnt_q <= '0;
            last_idx_q <= '0;
        end else begin
            if (in_valid && in_ready) begin
                take_cnt_q <= (take_cnt_q == BW'(D - 1)) ? '0 : take_cnt_q + 1'b1;
            end
            if (out_valid) begin
                last_idx_q <= out_index;
            end
        end
    end

    // R5
    trig_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && take_cnt_q == BW'(D - 1)) |=> !in_ready);

    // R5
    busy_out_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_index != BW'(D - 1)) |-> !in_ready);

    // R3
    first_index_chk: assert property (@(posedge clk) disable iff (rst)
        out_first |-> (out_valid && out_index == '0));

    // R3
    spacing_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R3
    index_seq_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_first) |-> (out_index == last_idx_q + 1'b1));
endmodule

bind pfb_channelizer pfb_chk #(.D(D), .NTAP(NTAP), .BW(BW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_first (out_first),
    .out_index (out_index)
);

// File: tb/tb_pfb_channelizer.sv
module tb_pfb_channelizer;
    localparam int CLK_PERIOD = 10;
    localparam int D     = 16;
    localparam int NTAP  = 8;
    localparam int DW    = 14;
    localparam int CW    = 18;
    localparam int OW    = 18;
    localparam int SHIFT = 17;
    localparam int BW    = $clog2(D);
    localparam int CAW   = $clog2(D * NTAP);

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic                 in_ready;
    logic signed [DW-1:0] in_sample = '0;
    logic                 coef_we = 1'b0;
    logic [CAW-1:0]       coef_addr = '0;
    logic signed [CW-1:0] coef_data = '0;
    logic                 out_valid;
    logic                 out_first;
    logic [BW-1:0]        out_index;
    logic signed [OW-1:0] out_data;

    pfb_channelizer #(
        .D(D), .NTAP(NTAP), .DW(DW), .CW(CW), .OW(OW), .SHIFT(SHIFT)
    ) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_sample(in_sample), .coef_we(coef_we), .coef_addr(coef_addr),
        .coef_data(coef_data), .out_valid(out_valid), .out_first(out_first),
        .out_index(out_index), .out_data(out_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int     checks = 0;
    int     errors = 0;
    bit     finished = 0;
    longint h  [D * NTAP];
    longint xs [4096];
    int     hist_n = 0;
    longint cap_data  [D];
    int     cap_index [D];
    bit     cap_first [D];
    int     words = 0;
    int     seed = 12345;

    always @(negedge clk) begin
        if (out_valid) begin
            if (words < D) begin
                cap_data[words]  = out_data;
                cap_index[words] = out_index;
                cap_first[words] = out_first;
            end
            words++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic write_coef(input int a, input longint v);
        @(negedge clk);
        coef_we   = 1'b1;
        coef_addr = CAW'(a);
        coef_data = CW'(v);
        h[a]      = v;
        @(negedge clk);
        coef_we   = 1'b0;
    endtask

    task automatic load_pattern(input int mul, input int off);
        for (int a = 0; a < D * NTAP; a++) begin
            write_coef(a, longint'(((a * mul + off) % 200) - 100) * 997);
        end
    endtask

    task automatic push(input longint v);
        @(negedge clk);
        in_valid  = 1'b1;
        in_sample = DW'(v);
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        xs[hist_n] = v;
        hist_n++;
    endtask

    function automatic longint model(input int k);
        longint acc = 0;
        int e = hist_n - 1;
        for (int n = 0; n < NTAP; n++) begin
            int idx = e - k - n * D;
            if (idx >= 0) acc += h[n * D + k] * xs[idx];
        end
        return (acc + (longint'(1) <<< (SHIFT - 1))) >>> SHIFT;
    endfunction

    task automatic check_frame(input string req);
        int t = 0;
        while (words < D && t < 20 * D * NTAP) begin
            @(negedge clk);
            t++;
        end
        chk(words == D, req, "frame word count", words, D);
        for (int k = 0; k < D; k++) begin
            chk(cap_data[k] == model(k), req, $sformatf("branch %0d value", k),
                cap_data[k], model(k));
            chk(cap_index[k] == k, "R3", "word index", cap_index[k], k);
            chk(cap_first[k] == (k == 0), "R3", "first flag", cap_first[k], (k == 0));
        end
        @(negedge clk);
        words = 0;
    endtask

    function automatic longint lcg();
        seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
        return longint'((seed >>> 8) % 16383) - 8191;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        hist_n = 0;
        words  = 0;
    endtask

    task automatic test_reset_state();
        do_reset();
        chk(out_valid == 1'b0, "R8", "out_valid after reset", out_valid, 0);
        chk(in_ready == 1'b1, "R8", "in_ready after reset", in_ready, 1);
    endtask

    task automatic test_impulse();
        // R1 R2: one impulse walks down branch D-1 across eight frames
        push(1000);
        for (int i = 1; i < D; i++) push(0);
        check_frame("R1");
        for (int m = 1; m < NTAP; m++) begin
            for (int i = 0; i < D; i++) push(0);
            check_frame("R2");
        end
        // impulse landing on branch 3 of a new frame
        for (int i = 0; i < D; i++) push((i == D - 1 - 3) ? 2500 : 0);
        check_frame("R1");
    endtask

    task automatic test_random();
        for (int f = 0; f < 6; f++) begin
            for (int i = 0; i < D; i++) push(lcg());
            check_frame("R4");
        end
    endtask

    task automatic test_full_scale();
        for (int a = 0; a < D * NTAP; a++) write_coef(a, -131072);
        for (int f = 0; f < NTAP + 1; f++) begin
            for (int i = 0; i < D; i++) push(-8192);
            check_frame("R4");
        end
        chk(cap_data[D - 1] == 65536, "R4", "full-scale result", cap_data[D - 1], 65536);
    endtask

    task automatic test_stall();
        int c = 0;
        int fc = 0;
        for (int i = 0; i < D; i++) push(lcg());
        // hold a sample on the input for the whole stall
        in_valid  = 1'b1;
        in_sample = DW'(1234);
        do begin
            @(negedge clk);
            c++;
            if (out_valid && out_first) fc = c;
        end while (!in_ready);
        in_valid = 1'b0;
        chk(c - 1 == 8 * D, "R5", "cycles with in_ready low", c - 1, 8 * D);
        chk(fc == 9, "R5", "first word delay", fc, 9);
        check_frame("R5");
        for (int i = 0; i < D; i++) push(lcg());
        check_frame("R5");
    endtask

    task automatic test_coef_rewrite();
        load_pattern(53, 7);
        for (int f = 0; f < 3; f++) begin
            for (int i = 0; i < D; i++) push(lcg());
            check_frame("R7");
        end
        write_coef(2 * D + 5, 120000);
        for (int i = 0; i < D; i++) push(lcg());
        check_frame("R7");
    endtask

    task automatic test_mid_reset();
        int t = 0;
        for (int i = 0; i < 5; i++) push(3000);
        do_reset();
        for (int i = 0; i < D - 1; i++) push(lcg());
        while (t < 20) begin
            @(negedge clk);
            t++;
        end
        chk(words == 0, "R6", "no frame before D samples", words, 0);
        push(lcg());
        check_frame("R6");
        for (int i = 0; i < D; i++) push(lcg());
        check_frame("R6");
    endtask

    initial begin
        load_pattern(37, 11);
        test_reset_state();
        test_impulse();
        test_random();
        test_stall();
        test_coef_rewrite();
        test_full_scale();
        load_pattern(29, 3);
        test_mid_reset();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule